// File: doc/BRIEF.md
# Microcontroller External Memory Glue

This block connects an 8051-family microcontroller to one byte-wide SRAM that holds both program code and data. The controller puts the low address byte and the data byte on one shared port. The glue captures the address byte when the address-latch strobe pulses and drives it onto the SRAM's low address lines. It combines the high address byte with the program-fetch strobe, the read strobe and the write strobe to produce active-low chip and output enables for the SRAM.

One data page is kept away from the SRAM. A single address in that page is a write-only latch that drives a seven-segment display, with seven segments and a decimal point. The glue also generates the controller's crystal clock by dividing its own clock. It holds the controller in reset for a fixed time after a global reset, and while the controller is held in reset the SRAM stays disabled. A build parameter chooses between a 32 KB memory and a 128 KB memory. The 128 KB build has an extra top address line that separates code space from data space.

Top module: `mcu_sram_glue`

## Requirements
- R1: While `rst_n` is low, `mcu_rst` is 1, `mcu_xtal` is 0, `seg` is 0x00, `sram_addr_lo` is 0x00, and both `sram_ce_n` and `sram_oe_n` are 1.
- R2: After `rst_n` rises, `mcu_rst` stays 1 for exactly RST_CYCLES rising clock edges. It then goes to 0 and stays 0 until the next global reset.
- R3: `mcu_xtal` toggles once every CLK_DIV/2 clock edges, which gives a 50% duty cycle at the clock frequency divided by CLK_DIV. The first toggle comes CLK_DIV/2 edges after reset is released.
- R4: While `ale` is high, `sram_addr_lo` follows `ad_bus` with a delay of three clock edges. The byte that was on `ad_bus` when `ale` fell is held until `ale` goes high again.
- R5: A code fetch (`psen_n`=0) drives both `sram_ce_n` and `sram_oe_n` to 0 at any high address byte, including the display page.
- R6: A data read (`rd_n`=0) or a data write (`wr_n`=0) outside the display page drives `sram_ce_n` to 0. `sram_oe_n` is 0 for a read and 1 whenever `wr_n` is 0.
- R7: A data read or write with `addr_hi` equal to DISP_PAGE (default 0xFF) keeps both `sram_ce_n` and `sram_oe_n` at 1.
- R8: With no strobe active, or while `mcu_rst` is 1, both `sram_ce_n` and `sram_oe_n` are 1.
- R9: A data write to `addr_hi`=DISP_PAGE with a captured low byte of DISP_LO (default 0x00) loads `seg` with `ad_bus` as it was when `wr_n` rose. The new value appears within three clock edges. A write to any other address leaves `seg` unchanged.
- R10: When LARGE_MEM is 1, `sram_a16` is 0 during a code fetch (`psen_n`=0) and 1 otherwise. When LARGE_MEM is 0, it is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Global reset, active low |
| ale | input | 1 | Address-latch strobe from the controller |
| psen_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low (port 3 bit 6) |
| ad_bus | input | 8 | Shared low-address/data port |
| addr_hi | input | 8 | High address byte |
| sram_addr_lo | output | 8 | Captured low address for the SRAM |
| sram_a16 | output | 1 | Code/data select line for the large memory |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| mcu_xtal | output | 1 | Divided clock to the controller crystal input |
| mcu_rst | output | 1 | Controller reset, active high |
| seg | output | 8 | Display latch: segments in bits 6:0, decimal point in bit 7 |

## Verification
The decode is tried with each kind of strobe (fetch, read, write and idle) at an ordinary page and at the display page. This shows that the carve-out applies only to data accesses and never to code fetches. The address capture is tested with bytes that change both while the strobe is high and after it falls, which separates transparent behaviour from hold behaviour. Display writes go to the mapped address, to a neighbouring address in the same page, and to an ordinary page, so a latch that decodes only the page is caught. The reset and clock outputs are checked edge by edge from the release of global reset.

// File: rtl/mcu_sram_glue.sv
module mcu_sram_glue #(
  parameter int         CLK_DIV    = 2,
  parameter int         RST_CYCLES = 16,
  parameter int         LARGE_MEM  = 1,
  parameter logic [7:0] DISP_PAGE  = 8'hFF,
  parameter logic [7:0] DISP_LO    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic       psen_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] ad_bus,
  input  logic [7:0] addr_hi,
  output logic [7:0] sram_addr_lo,
  output logic       sram_a16,
  output logic       sram_ce_n,
  output logic       sram_oe_n,
  output logic       mcu_xtal,
  output logic       mcu_rst,
  output logic [7:0] seg
);

  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int RW   = $clog2(RST_CYCLES + 1);

  logic [1:0]    ale_s;
  logic [2:0]    wr_s;
  logic [7:0]    ad_d1, ad_d2, hi_d1, hi_d2;
  logic [DW-1:0] dcnt;
  logic [RW-1:0] rcnt;
  logic          wr_rise, in_page, code_acc, data_acc, sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_s <= '0;
      wr_s  <= '1;
      ad_d1 <= '0;
      ad_d2 <= '0;
      hi_d1 <= '0;
      hi_d2 <= '0;
    end else begin
      ale_s <= {ale_s[0], ale};
      wr_s  <= {wr_s[1:0], wr_n};
      ad_d1 <= ad_bus;
      ad_d2 <= ad_d1;
      hi_d1 <= addr_hi;
      hi_d2 <= hi_d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sram_addr_lo <= '0;
    else if (ale_s[1]) sram_addr_lo <= ad_d2;
  end

  assign wr_rise = wr_s[1] & ~wr_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seg <= '0;
    else if (wr_rise && hi_d2 == DISP_PAGE && sram_addr_lo == DISP_LO)
      seg <= ad_d2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt     <= '0;
      mcu_xtal <= 1'b0;
    end else if (dcnt == DW'(HALF - 1)) begin
      dcnt     <= '0;
      mcu_xtal <= ~mcu_xtal;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rcnt <= '0;
    else if (rcnt != RW'(RST_CYCLES)) rcnt <= rcnt + 1'b1;
  end

  assign mcu_rst = (rcnt != RW'(RST_CYCLES));

  assign in_page   = (addr_hi == DISP_PAGE);
  assign code_acc  = ~psen_n;
  assign data_acc  = (~rd_n | ~wr_n) & ~in_page;
  assign sel       = ~mcu_rst & (code_acc | data_acc);
  assign sram_ce_n = ~sel;
  assign sram_oe_n = ~(sel & wr_n & (code_acc | ~rd_n));

  generate
    if (LARGE_MEM != 0) begin : g_large
      assign sram_a16 = psen_n;
    end else begin : g_small
      assign sram_a16 = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mcu_sram_glue_chk.sv
module mcu_sram_glue_chk #(
  parameter logic [7:0] DISP_PAGE = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic       wr_n,
  input logic [7:0] addr_hi,
  input logic [7:0] sram_addr_lo,
  input logic       sram_ce_n,
  input logic       sram_oe_n,
  input logic       mcu_rst
);

  logic [1:0] ale_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ale_lo_cnt <= '0;
    else if (ale)                   ale_lo_cnt <= '0;
    else if (ale_lo_cnt != 2'd3)    ale_lo_cnt <= ale_lo_cnt + 1'b1;
  end

  assert_isolate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_rst |-> (sram_ce_n && sram_oe_n));

  assert_oe_within_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_ce_n);

  assert_no_oe_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> sram_oe_n);

  assert_page_carved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && addr_hi == DISP_PAGE) |-> sram_ce_n);

  assert_rst_stays_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mcu_rst |=> !mcu_rst);

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_lo_cnt == 2'd3) |-> $stable(sram_addr_lo));

endmodule

bind mcu_sram_glue mcu_sram_glue_chk #(.DISP_PAGE(DISP_PAGE)) chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .wr_n(wr_n),
  .addr_hi(addr_hi), .sram_addr_lo(sram_addr_lo), .sram_ce_n(sram_ce_n),
  .sram_oe_n(sram_oe_n), .mcu_rst(mcu_rst)
);

// File: tb/mcu_sram_glue_tb_top.sv
module mcu_sram_glue_tb_top;

  localparam int DIV  = 4;
  localparam int RSTC = 8;

  logic       clk = 1'b0;
  logic       rst_n, ale, psen_n, rd_n, wr_n;
  logic [7:0] ad_bus, addr_hi;
  logic [7:0] sram_addr_lo, seg;
  logic       sram_a16, sram_ce_n, sram_oe_n, mcu_xtal, mcu_rst;

  always #10 clk = ~clk;

  mcu_sram_glue #(.CLK_DIV(DIV), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_bus(ad_bus), .addr_hi(addr_hi),
    .sram_addr_lo(sram_addr_lo), .sram_a16(sram_a16), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .mcu_xtal(mcu_xtal), .mcu_rst(mcu_rst), .seg(seg)
  );

  typedef enum int {S_CE, S_OE, S_ADDR, S_A16, S_XTAL, S_RST, S_SEG} sel_t;
  typedef struct {
    string      req;
    sel_t       sel;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  function automatic logic [7:0] actual(sel_t s);
    case (s)
      S_CE:    return {7'd0, sram_ce_n};
      S_OE:    return {7'd0, sram_oe_n};
      S_ADDR:  return sram_addr_lo;
      S_A16:   return {7'd0, sram_a16};
      S_XTAL:  return {7'd0, mcu_xtal};
      S_RST:   return {7'd0, mcu_rst};
      default: return seg;
    endcase
  endfunction

  task automatic expect_out(string req, sel_t s, logic [7:0] e);
    item_t it;
    it.req = req; it.sel = s; it.exp = e;
    q.push_back(it);
    #1;
  endtask

  initial begin
    forever begin
      item_t it;
      logic [7:0] a;
      wait (q.size() > 0);
      it = q.pop_front();
      a  = actual(it.sel);
      checks++;
      if (a !== it.exp) begin
        errors++;
        $display("FAIL %s %s: actual=%h expected=%h", it.req, it.sel.name(), a, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic access(logic [7:0] hi, logic p, logic r, logic w);
    @(negedge clk);
    addr_hi = hi; psen_n = p; rd_n = r; wr_n = w;
    #1;
  endtask

  task automatic capture(logic [7:0] v);
    @(negedge clk);
    ale = 1'b1; ad_bus = v;
    step(3);
    @(negedge clk);
    ale = 1'b0;
    step(4);
  endtask

  task automatic disp_write(logic [7:0] hi, logic [7:0] lo, logic [7:0] d);
    capture(lo);
    @(negedge clk);
    addr_hi = hi; ad_bus = d; wr_n = 1'b0;
    step(2);
    @(negedge clk);
    wr_n = 1'b1;
    step(3);
  endtask

  initial begin
    rst_n = 1'b0; ale = 1'b0; psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    ad_bus = 8'h00; addr_hi = 8'h00;
    step(3);
    expect_out("R1", S_RST, 8'd1);
    expect_out("R1", S_XTAL, 8'd0);
    expect_out("R1", S_SEG, 8'h00);
    expect_out("R1", S_ADDR, 8'h00);
    expect_out("R1", S_CE, 8'd1);
    expect_out("R1", S_OE, 8'd1);
    access(8'h12, 1'b0, 1'b1, 1'b1);
    expect_out("R8", S_CE, 8'd1);
    expect_out("R8", S_OE, 8'd1);
    access(8'h12, 1'b1, 1'b1, 1'b1);

    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= RSTC + 2; k++) begin
      step(1);
      expect_out("R3", S_XTAL, 8'((k / (DIV / 2)) % 2));
      expect_out("R2", S_RST, (k < RSTC) ? 8'd1 : 8'd0);
    end

    access(8'h12, 1'b1, 1'b1, 1'b1);
    expect_out("R8", S_CE, 8'd1);
    expect_out("R8", S_OE, 8'd1);
    access(8'h12, 1'b0, 1'b1, 1'b1);
    expect_out("R5", S_CE, 8'd0);
    expect_out("R5", S_OE, 8'd0);
    expect_out("R10", S_A16, 8'd0);
    access(8'hFF, 1'b0, 1'b1, 1'b1);
    expect_out("R5", S_CE, 8'd0);
    expect_out("R5", S_OE, 8'd0);
    access(8'h40, 1'b1, 1'b0, 1'b1);
    expect_out("R6", S_CE, 8'd0);
    expect_out("R6", S_OE, 8'd0);
    expect_out("R10", S_A16, 8'd1);
    access(8'h40, 1'b1, 1'b1, 1'b0);
    expect_out("R6", S_CE, 8'd0);
    expect_out("R6", S_OE, 8'd1);
    access(8'hFF, 1'b1, 1'b0, 1'b1);
    expect_out("R7", S_CE, 8'd1);
    expect_out("R7", S_OE, 8'd1);
    access(8'hFF, 1'b1, 1'b1, 1'b0);
    expect_out("R7", S_CE, 8'd1);
    expect_out("R7", S_OE, 8'd1);
    access(8'h00, 1'b1, 1'b1, 1'b1);

    @(negedge clk);
    ale = 1'b1; ad_bus = 8'h11;
    step(3);
    expect_out("R4", S_ADDR, 8'h11);
    @(negedge clk);
    ad_bus = 8'h5A;
    step(3);
    expect_out("R4", S_ADDR, 8'h5A);
    @(negedge clk);
    ale = 1'b0; ad_bus = 8'hA5;
    step(5);
    expect_out("R4", S_ADDR, 8'h5A);

    disp_write(8'hFF, 8'h00, 8'hC3);
    expect_out("R9", S_SEG, 8'hC3);
    disp_write(8'hFF, 8'h01, 8'h3C);
    expect_out("R9", S_SEG, 8'hC3);
    disp_write(8'h40, 8'h00, 8'h77);
    expect_out("R9", S_SEG, 8'hC3);
    disp_write(8'hFF, 8'h00, 8'h81);
    expect_out("R9", S_SEG, 8'h81);

    wait (q.size() == 0);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule